// File: doc/BRIEF.md
# Serial Controller Host Register Front End

This block sits between a byte-wide microprocessor bus and the transmit and receive engines of an asynchronous serial controller. The host selects the block with an active-low chip select and chooses the path with a command/data select line. Command writes are decoded into six configuration slots. Status reads return one of two status bytes, taking turns. Data writes and data reads are not stored here: each one only produces a one-cycle strobe toward the transmit or receive buffer.

The host bus is synchronous to the block clock. A transfer completes on the clock edge at which its strobe returns high, and chip select, command/data select and the write byte are taken from the cycle before that edge. The bidirectional data bus is split into an input, an output and an output enable, so that a pad cell can make the tristate. The receiver reports errors as single-cycle pulses, and the block holds them as sticky flags until the host clears them.

Top module: `hcr_top`

## Requirements
- R1: After reset, every configuration output, `cfg_done`, every error flag and the pending-address flag are 0, and the first status read returns status 1.
- R2: A command byte's bits 7:6 choose its slot: 00 frame (keeps bits 5:0), 01 rate (keeps bits 5:0), 10 control (keeps bits 4:0), 11 with bit 5 = 0 mode (keeps bits 4:0), 11 with bit 5 = 1 block (keeps bits 4:0).
- R3: A mode write with bit 2 = 1 sets the pending-address flag. The next command write stores all 8 bits in `addr_cfg`, is not decoded by bits 7:6, and clears the flag.
- R4: `parity_en` is frame bit 3. `crc_en` is frame bit 2 only while frame bit 3 is 0.
- R5: `cfg_done` rises only once all six slots, including the address slot, have been written since reset. `tx_enable` and `rx_enable` are control bits 0 and 1, each gated by `cfg_done`.
- R6: Status reads alternate between status 1 and status 2. Data reads and bus cycles without chip select do not advance the alternation.
- R7: Status 1 is {0, crc err, parity err, overrun, framing err, `tx_empty`, `rx_avail`, `cfg_done`} from bit 7 down to bit 0. Status 2 is {1, pending-address, `tx_enable`, `rx_enable`, `parity_en`, `crc_en`, 0, 0}.
- R8: `rx_err_pulse` bits 3..0 (crc, parity, overrun, framing) set sticky flags. A control write with bit 5 = 1 clears all four flags. A pulse in the same cycle as a clear leaves its flag set.
- R9: A data write pulses `tx_push` for one cycle with the written byte on `tx_byte` and changes no configuration. A data read shows `rx_data` on the bus and pulses `rx_pop` for one cycle at its end.
- R10: `host_d_oe` is 1 only while `cs_n` and `rd_n` are both 0.
- R11: Write and read strobes with `cs_n` high change no state and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| cd_sel | input | 1 | 1 = command/status path, 0 = data path |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| host_d_i | input | 8 | Bus byte from the host |
| host_d_o | output | 8 | Bus byte to the host |
| host_d_oe | output | 1 | Output enable for the pad |
| rx_err_pulse | input | 4 | Receiver error pulses {crc, parity, overrun, framing} |
| tx_empty | input | 1 | Transmit buffer empty, shown in status 1 |
| rx_avail | input | 1 | Receive data available, shown in status 1 |
| rx_data | input | 8 | Head byte of the receive buffer |
| tx_push | output | 1 | One-cycle strobe for a data write |
| tx_byte | output | 8 | Byte carried by the data write |
| rx_pop | output | 1 | One-cycle strobe at the end of a data read |
| frame_cfg | output | 6 | Frame slot contents |
| rate_cfg | output | 6 | Rate slot contents |
| ctrl_cfg | output | 5 | Control slot contents |
| mode_cfg | output | 5 | Mode slot contents |
| addr_cfg | output | 8 | Address byte |
| blk_cfg | output | 5 | Block slot contents |
| parity_en | output | 1 | Parity enabled |
| crc_en | output | 1 | CRC enabled (after parity priority) |
| tx_enable | output | 1 | Transmitter enabled |
| rx_enable | output | 1 | Receiver enabled |
| cfg_done | output | 1 | All six slots loaded |

## Verification
The bench builds the block with the package defaults: an 8-bit bus and four error flags. At these sizes every status bit, every slot and every payload width can be reached with only a few hundred bus cycles. Random command bytes often hit the mode encoding with bit 2 set, so the address byte path and its interaction with the alternation get exercised many times. Directed cases cover the parity/CRC conflict, a clear that collides with an error pulse, and bus cycles made without chip select.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

  localparam int BUS_W  = 8;
  localparam int ERR_W  = 4;
  localparam int N_SLOT = 6;

  typedef enum logic [2:0] {
    SLOT_FRAME = 3'd0,
    SLOT_RATE  = 3'd1,
    SLOT_CTRL  = 3'd2,
    SLOT_MODE  = 3'd3,
    SLOT_ADDR  = 3'd4,
    SLOT_BLK   = 3'd5
  } slot_e;

  // Slot chosen by a command byte that is not an address byte.
  function automatic slot_e slot_of(input logic [BUS_W-1:0] b);
    case (b[7:6])
      2'b00:   slot_of = SLOT_FRAME;
      2'b01:   slot_of = SLOT_RATE;
      2'b10:   slot_of = SLOT_CTRL;
      default: slot_of = b[5] ? SLOT_BLK : SLOT_MODE;
    endcase
  endfunction

  // Number of payload bits each slot keeps.
  function automatic int payload_w(input int s);
    case (s)
      0, 1:    payload_w = 6;
      4:       payload_w = 8;
      default: payload_w = 5;
    endcase
  endfunction

  function automatic logic crc_effective(input logic par, input logic crc);
    crc_effective = crc & ~par;
  endfunction

  function automatic logic [BUS_W-1:0] pack_status1(input logic [ERR_W-1:0] err,
                                                    input logic txe, input logic rxa,
                                                    input logic done);
    pack_status1 = {1'b0, err, txe, rxa, done};
  endfunction

  function automatic logic [BUS_W-1:0] pack_status2(input logic pend, input logic txen,
                                                    input logic rxen, input logic par,
                                                    input logic crc);
    pack_status2 = {1'b1, pend, txen, rxen, par, crc, 2'b00};
  endfunction

endpackage

// File: rtl/hcr_bus_sync.sv
module hcr_bus_sync
  import hcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             cd_sel,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [BUS_W-1:0] host_d_i,
  output logic             cmd_wr,
  output logic             data_wr,
  output logic             st_rd_done,
  output logic             data_rd_done,
  output logic [BUS_W-1:0] wr_byte,
  output logic             tx_push,
  output logic [BUS_W-1:0] tx_byte,
  output logic             rx_pop
);

  logic             rd_q, wr_q, cs_q, cd_q;
  logic [BUS_W-1:0] d_q;
  logic             wr_end, rd_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
      cs_q <= 1'b1;
      cd_q <= 1'b0;
      d_q  <= '0;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
      cs_q <= cs_n;
      cd_q <= cd_sel;
      d_q  <= host_d_i;
    end
  end

  // A transfer ends when its strobe returns high after a selected low cycle.
  assign wr_end       = !wr_q && wr_n && !cs_q;
  assign rd_end       = !rd_q && rd_n && !cs_q;
  assign cmd_wr       = wr_end && cd_q;
  assign data_wr      = wr_end && !cd_q;
  assign st_rd_done   = rd_end && cd_q;
  assign data_rd_done = rd_end && !cd_q;
  assign wr_byte      = d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_push <= 1'b0;
      tx_byte <= '0;
      rx_pop  <= 1'b0;
    end else begin
      tx_push <= data_wr;
      rx_pop  <= data_rd_done;
      if (data_wr) tx_byte <= d_q;
    end
  end

endmodule

// File: rtl/hcr_cmd_regs.sv
module hcr_cmd_regs
  import hcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [BUS_W-1:0] wr_byte,
  output logic [5:0]       frame_cfg,
  output logic [5:0]       rate_cfg,
  output logic [4:0]       ctrl_cfg,
  output logic [4:0]       mode_cfg,
  output logic [7:0]       addr_cfg,
  output logic [4:0]       blk_cfg,
  output logic             pend_q,
  output logic             err_clr,
  output logic             cfg_done
);

  slot_e             tgt;
  logic [N_SLOT-1:0] we;
  logic [N_SLOT-1:0] loaded_q;

  assign tgt = slot_of(wr_byte);

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    localparam int PW = payload_w(s);
    logic [PW-1:0] q;

    assign we[s] = cmd_wr && (pend_q ? (s == int'(SLOT_ADDR))
                                     : (s != int'(SLOT_ADDR)) && (tgt == slot_e'(s)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (we[s]) q <= wr_byte[PW-1:0];
    end
  end

  assign frame_cfg = g_slot[0].q;
  assign rate_cfg  = g_slot[1].q;
  assign ctrl_cfg  = g_slot[2].q;
  assign mode_cfg  = g_slot[3].q;
  assign addr_cfg  = g_slot[4].q;
  assign blk_cfg   = g_slot[5].q;

  assign err_clr = cmd_wr && !pend_q && (tgt == SLOT_CTRL) && wr_byte[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      loaded_q <= '0;
    end else begin
      loaded_q <= loaded_q | we;
      if (cmd_wr) pend_q <= !pend_q && (tgt == SLOT_MODE) && wr_byte[2];
    end
  end

  assign cfg_done = &loaded_q;

endmodule

// File: rtl/hcr_err_flags.sv
module hcr_err_flags
  import hcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ERR_W-1:0] set_p,
  output logic [ERR_W-1:0] err_q
);

  for (genvar i = 0; i < ERR_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err_q[i] <= 1'b0;
      else if (set_p[i]) err_q[i] <= 1'b1;
      else if (clr)      err_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/hcr_status_sel.sv
module hcr_status_sel
  import hcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_rd_done,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             cd_sel,
  input  logic [BUS_W-1:0] st1,
  input  logic [BUS_W-1:0] st2,
  input  logic [BUS_W-1:0] rx_data,
  output logic             sel_q,
  output logic [BUS_W-1:0] host_d_o,
  output logic             host_d_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sel_q <= 1'b0;
    else if (st_rd_done) sel_q <= ~sel_q;
  end

  always_comb begin
    if (!cd_sel)    host_d_o = rx_data;
    else if (sel_q) host_d_o = st2;
    else            host_d_o = st1;
  end

  assign host_d_oe = !cs_n && !rd_n;

endmodule

// File: rtl/hcr_top.sv
module hcr_top
  import hcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             cd_sel,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [BUS_W-1:0] host_d_i,
  output logic [BUS_W-1:0] host_d_o,
  output logic             host_d_oe,
  input  logic [ERR_W-1:0] rx_err_pulse,
  input  logic             tx_empty,
  input  logic             rx_avail,
  input  logic [BUS_W-1:0] rx_data,
  output logic             tx_push,
  output logic [BUS_W-1:0] tx_byte,
  output logic             rx_pop,
  output logic [5:0]       frame_cfg,
  output logic [5:0]       rate_cfg,
  output logic [4:0]       ctrl_cfg,
  output logic [4:0]       mode_cfg,
  output logic [7:0]       addr_cfg,
  output logic [4:0]       blk_cfg,
  output logic             parity_en,
  output logic             crc_en,
  output logic             tx_enable,
  output logic             rx_enable,
  output logic             cfg_done
);

  logic             cmd_wr, data_wr, st_rd_done, data_rd_done;
  logic [BUS_W-1:0] wr_byte;
  logic             pend_q, err_clr, sel_q;
  logic [ERR_W-1:0] err_q;
  logic [BUS_W-1:0] st1, st2;

  hcr_bus_sync u_sync (
    .clk, .rst_n, .cs_n, .cd_sel, .rd_n, .wr_n, .host_d_i,
    .cmd_wr, .data_wr, .st_rd_done, .data_rd_done, .wr_byte,
    .tx_push, .tx_byte, .rx_pop
  );

  hcr_cmd_regs u_regs (
    .clk, .rst_n, .cmd_wr, .wr_byte,
    .frame_cfg, .rate_cfg, .ctrl_cfg, .mode_cfg, .addr_cfg, .blk_cfg,
    .pend_q, .err_clr, .cfg_done
  );

  hcr_err_flags u_err (
    .clk, .rst_n, .clr(err_clr), .set_p(rx_err_pulse), .err_q
  );

  assign parity_en = frame_cfg[3];
  assign crc_en    = crc_effective(frame_cfg[3], frame_cfg[2]);
  assign tx_enable = ctrl_cfg[0] && cfg_done;
  assign rx_enable = ctrl_cfg[1] && cfg_done;

  assign st1 = pack_status1(err_q, tx_empty, rx_avail, cfg_done);
  assign st2 = pack_status2(pend_q, tx_enable, rx_enable, parity_en, crc_en);

  hcr_status_sel u_stat (
    .clk, .rst_n, .st_rd_done, .cs_n, .rd_n, .cd_sel,
    .st1, .st2, .rx_data, .sel_q, .host_d_o, .host_d_oe
  );

endmodule

// File: rtl/hcr_checker.sv
module hcr_checker
  import hcr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             parity_en,
  input logic             crc_en,
  input logic             tx_enable,
  input logic             rx_enable,
  input logic             cfg_done,
  input logic             tx_push,
  input logic             cmd_wr,
  input logic             pend_q,
  input logic             err_clr,
  input logic [ERR_W-1:0] err_q,
  input logic             st_rd_done,
  input logic             sel_q
);

  assert_parity_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(parity_en && crc_en));

  assert_enable_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enable || rx_enable) |-> cfg_done);

  assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd_done |=> (sel_q != $past(sel_q)));

  assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !st_rd_done |=> $stable(sel_q));

  assert_addr_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cmd_wr) |=> !pend_q);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> ((err_q & $past(err_q)) == $past(err_q)));

  assert_push_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_push);

endmodule

bind hcr_top hcr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .parity_en(parity_en), .crc_en(crc_en),
  .tx_enable(tx_enable), .rx_enable(rx_enable), .cfg_done(cfg_done),
  .tx_push(tx_push), .cmd_wr(cmd_wr), .pend_q(pend_q), .err_clr(err_clr),
  .err_q(err_q), .st_rd_done(st_rd_done), .sel_q(sel_q)
);

// File: tb/hcr_top_tb_top.sv
module hcr_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, cd_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] host_d_i = '0;
  logic [7:0] host_d_o;
  logic       host_d_oe;
  logic [3:0] rx_err_pulse = '0;
  logic       tx_empty = 1'b0, rx_avail = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_push, rx_pop;
  logic [7:0] tx_byte;
  logic [5:0] frame_cfg, rate_cfg;
  logic [4:0] ctrl_cfg, mode_cfg, blk_cfg;
  logic [7:0] addr_cfg;
  logic       parity_en, crc_en, tx_enable, rx_enable, cfg_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench model
  logic [7:0] m_reg [6];
  logic [5:0] m_loaded;
  logic       m_pend, m_sel;
  logic [3:0] m_err;

  always #10 clk = ~clk;

  hcr_top dut_i (
    .clk, .rst_n, .cs_n, .cd_sel, .rd_n, .wr_n, .host_d_i, .host_d_o, .host_d_oe,
    .rx_err_pulse, .tx_empty, .rx_avail, .rx_data, .tx_push, .tx_byte, .rx_pop,
    .frame_cfg, .rate_cfg, .ctrl_cfg, .mode_cfg, .addr_cfg, .blk_cfg,
    .parity_en, .crc_en, .tx_enable, .rx_enable, .cfg_done
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int slot_for(input logic [7:0] b);
    if (b[7:6] == 2'b00) return 0;
    if (b[7:6] == 2'b01) return 1;
    if (b[7:6] == 2'b10) return 2;
    return b[5] ? 5 : 3;
  endfunction

  function automatic logic [7:0] keep_mask(input int s);
    if (s <= 1) return 8'h3F;
    if (s == 4) return 8'hFF;
    return 8'h1F;
  endfunction

  function automatic logic e_done();   return &m_loaded; endfunction
  function automatic logic e_par();    return m_reg[0][3]; endfunction
  function automatic logic e_crc();    return m_reg[0][2] && !m_reg[0][3]; endfunction
  function automatic logic e_txen();   return m_reg[2][0] && e_done(); endfunction
  function automatic logic e_rxen();   return m_reg[2][1] && e_done(); endfunction
  function automatic logic [7:0] e_st1();
    return {1'b0, m_err, tx_empty, rx_avail, e_done()};
  endfunction
  function automatic logic [7:0] e_st2();
    return {1'b1, m_pend, e_txen(), e_rxen(), e_par(), e_crc(), 2'b00};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 6; i++) m_reg[i] = '0;
    m_loaded = '0; m_pend = 1'b0; m_sel = 1'b0; m_err = '0;
  endtask

  task automatic model_cmd(input logic [7:0] b, input logic [3:0] pulse);
    int s;
    if (m_pend) begin
      m_reg[4] = b; m_loaded[4] = 1'b1; m_pend = 1'b0;
    end else begin
      s = slot_for(b);
      m_reg[s] = b & keep_mask(s);
      m_loaded[s] = 1'b1;
      if (s == 2 && b[5]) m_err = '0;
      if (s == 3) m_pend = b[2];
    end
    m_err = m_err | pulse;
  endtask

  task automatic check_cfg(input string tag);
    chk({tag, " frame"}, {2'b0, frame_cfg}, m_reg[0]);
    chk({tag, " rate"},  {2'b0, rate_cfg},  m_reg[1]);
    chk({tag, " ctrl"},  {3'b0, ctrl_cfg},  m_reg[2]);
    chk({tag, " mode"},  {3'b0, mode_cfg},  m_reg[3]);
    chk({tag, " addr"},  addr_cfg,          m_reg[4]);
    chk({tag, " blk"},   {3'b0, blk_cfg},   m_reg[5]);
    chk({tag, " flags"}, {3'b0, parity_en, crc_en, tx_enable, rx_enable, cfg_done},
        {3'b0, e_par(), e_crc(), e_txen(), e_rxen(), e_done()});
  endtask

  // Bus write; pulse is applied to rx_err_pulse in the completing cycle.
  task automatic bus_write(input logic sel, input logic cd, input logic [7:0] b,
                           input logic [3:0] pulse);
    @(negedge clk);
    cs_n = !sel; cd_sel = cd; host_d_i = b; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; rx_err_pulse = pulse;
    @(negedge clk);
    rx_err_pulse = '0;
    if (sel && !cd) begin
      chk("R9 tx_push high", {7'b0, tx_push}, 8'h01);
      chk("R9 tx_byte", tx_byte, b);
    end else begin
      chk("R11/R9 no tx_push", {7'b0, tx_push}, 8'h00);
      m_err = m_err | pulse;
    end
    if (sel && cd) model_cmd(b, pulse);
    else if (sel) m_err = m_err | pulse;
    cs_n = 1'b1;
    @(negedge clk);
    chk("R9 tx_push one cycle", {7'b0, tx_push}, 8'h00);
  endtask

  task automatic bus_read(input logic sel, input logic cd, output logic [7:0] got);
    @(negedge clk);
    cs_n = !sel; cd_sel = cd; rd_n = 1'b0;
    @(negedge clk);
    got = host_d_o;
    chk("R10 oe during read", {7'b0, host_d_oe}, {7'b0, sel});
    rd_n = 1'b1;
    @(negedge clk);
    chk("R9 rx_pop", {7'b0, rx_pop}, {7'b0, sel && !cd});
    chk("R10 oe released", {7'b0, host_d_oe}, 8'h00);
    cs_n = 1'b1;
  endtask

  task automatic status_read(input string tag);
    logic [7:0] got;
    logic [7:0] exp;
    exp = m_sel ? e_st2() : e_st1();
    bus_read(1'b1, 1'b1, got);
    chk(tag, got, exp);
    m_sel = ~m_sel;
  endtask

  task automatic err_pulse(input logic [3:0] p);
    @(negedge clk);
    rx_err_pulse = p;
    @(negedge clk);
    rx_err_pulse = '0;
    m_err = m_err | p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic [31:0] seedv;
    seedv = $urandom(32'h5EED_1234);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_cfg("R1 reset");
    chk("R1 no drive", {7'b0, host_d_oe}, 8'h00);
    status_read("R1 first read is status1");
    status_read("R6 second read is status2");

    // R11 cycles without chip select
    bus_write(1'b0, 1'b1, 8'h3F, 4'h0);
    check_cfg("R11 ignored write");
    bus_read(1'b0, 1'b1, got);
    status_read("R11 toggle unchanged");
    status_read("R6 alternate");

    // R2 decode of each slot
    bus_write(1'b1, 1'b1, 8'h3A, 4'h0);
    bus_write(1'b1, 1'b1, 8'h7F, 4'h0);
    bus_write(1'b1, 1'b1, 8'h83, 4'h0);
    bus_write(1'b1, 1'b1, 8'hDB, 4'h0);
    bus_write(1'b1, 1'b1, 8'hF6, 4'h0);
    check_cfg("R2 decode");
    chk("R5 not done yet", {7'b0, cfg_done}, 8'h00);

    // R3 address byte that looks like a mode command
    bus_write(1'b1, 1'b1, 8'hC4, 4'h0);
    status_read("R7 status1 layout");
    status_read("R3 pending in status2");
    bus_write(1'b1, 1'b1, 8'hC1, 4'h0);
    check_cfg("R3 address byte");
    chk("R5 done after address", {7'b0, cfg_done}, 8'h01);
    chk("R5 tx_enable", {7'b0, tx_enable}, 8'h01);

    // R4 parity wins over CRC
    bus_write(1'b1, 1'b1, 8'h0C, 4'h0);
    chk("R4 parity on", {7'b0, parity_en}, 8'h01);
    chk("R4 crc off", {7'b0, crc_en}, 8'h00);
    bus_write(1'b1, 1'b1, 8'h04, 4'h0);
    chk("R4 crc alone", {7'b0, crc_en}, 8'h01);

    // R8 sticky errors and clear collision
    tx_empty = 1'b1; rx_avail = 1'b1;
    err_pulse(4'b1001);
    bus_write(1'b1, 1'b1, 8'h40, 4'h0);
    if (m_sel) status_read("R6 realign");
    status_read("R8 sticky after command");
    status_read("R7 status2 layout");
    bus_write(1'b1, 1'b1, 8'hA3, 4'b0100);
    status_read("R8 pulse beats clear");
    status_read("R6 alternate again");
    bus_write(1'b1, 1'b1, 8'hA3, 4'h0);
    status_read("R8 cleared");
    status_read("R6 alternate more");

    // R9 data path
    bus_write(1'b1, 1'b0, 8'h5A, 4'h0);
    check_cfg("R9 data write no config change");
    rx_data = 8'hC3;
    bus_read(1'b1, 1'b0, got);
    chk("R9 data read byte", got, 8'hC3);
    status_read("R6 data read does not toggle");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 5));
      tx_empty = 1'($urandom_range(0, 1));
      rx_avail = 1'($urandom_range(0, 1));
      case (op)
        0, 1: bus_write(1'b1, 1'b1, 8'($urandom), 4'($urandom_range(0, 15) & 4'($urandom)));
        2:    status_read("R6/R7 random status");
        3:    begin
                logic [7:0] v;
                v = 8'($urandom);
                bus_write(1'b1, 1'b0, v, 4'h0);
              end
        4:    err_pulse(4'($urandom));
        default: begin
                rx_data = 8'($urandom);
                bus_read(1'b1, 1'b0, got);
                chk("R9 random data read", got, rx_data);
              end
      endcase
      if (n % 8 == 0) check_cfg("R2/R3/R5 random");
    end
    check_cfg("R2 final");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule